// File: doc/BRIEF.md
# Partitioned-Table Distributed Arithmetic FIR Filter

This block is a fixed-coefficient FIR filter that computes its inner product without a single multiplier. Each accepted input sample is pushed into a delay line of past samples. The stored samples are then walked bit-serially, one or several bit positions per clock. At every step, the bits taken from the same position of all taps form addresses into small constant tables. Each table covers a group of at most eight taps and holds, for every bit pattern, the sum of the coefficients whose bits are set. An adder tree joins the table outputs. A shift-accumulator then weights each bit position and builds the full sum.

The finished sum is rounded to the output format and clipped to its range. A one-cycle valid pulse marks each new result. The number of bit positions handled per clock is a parameter, and it trades table copies against clocks per sample. With one bit per clock the filter needs twelve clocks per sample. With four bits per clock it needs three clocks, but it carries four copies of the tables. The coefficients are an elaboration-time parameter.

Top module: `da_fir_top`

## Requirements
- R1: `in_data` is a signed 12-bit sample with 11 fraction bits, and tap 0 is the newest accepted sample. `COEFS` packs one signed 16-bit coefficient per tap, with all bits fractional. Tap i occupies bits [16*i +: 16].
- R2: A result equals the sum over taps of coefficient times sample, expressed with 11 output fraction bits. The exact sum is divided by 2^16 and rounded to nearest, with ties going toward plus infinity.
- R3: Taps are grouped into partitions of at most eight taps each, and the last partition takes the remainder. Each partition's table entry is the sum of the coefficients selected by its address bits. The partition outputs are added before accumulation, so a 10-tap filter gives correct results across both partitions.
- R4: `BPC` bit positions are processed per clock, and `BPC` must divide 12. The folding factor F is 12/BPC. If a strobe is sampled at clock edge e, `out_valid` goes high after edge e+F.
- R5: The sign bit position of every sample carries negative weight, so negative samples, including -2048, produce exact two's-complement results.
- R6: `out_valid` is high for one cycle per accepted sample. `out_data` changes only when `out_valid` rises, and it holds its value otherwise.
- R7: A strobe is accepted when the block is idle or is in the last cycle of a computation, so strobes spaced exactly F edges apart are all accepted. A strobe that arrives earlier in a computation is ignored: the delay line does not shift, and no extra result appears.
- R8: A synchronous active-high reset clears the delay line, the accumulator, the bit counter and the busy flag. After reset, `out_data` is 0 and `out_valid` is low, and any computation in progress produces no result.
- R9: A rounded result above 2047 is output as 2047, and a rounded result below -2048 is output as -2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 12 | Signed input sample |
| out_valid | output | 1 | One-cycle result pulse |
| out_data | output | 12 | Rounded, saturated filter output |

## Verification
The hardest situation to reach is a strobe that lands exactly on the last cycle of a computation. Close behind it is a strobe that lands mid-computation and must be dropped without disturbing the delay line. Random gaps from 1 to 16 cycles give both cases many times over. They are run on two instances: one processes one bit per clock, with a 12-cycle fold, and one processes four bits per clock, with a 3-cycle fold. The same gap is therefore an early strobe for one instance and a legal strobe for the other. Directed bursts at gaps of exactly 12 and 11 cycles pin down the acceptance boundary. Sign-matched sample patterns drive the sum past both saturation limits.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    // number of table partitions needed for a tap count
    function automatic int part_count(input int ntaps, input int psize);
        return (ntaps + psize - 1) / psize;
    endfunction

    // taps held by partition idx; the last one takes the remainder
    function automatic int part_taps(input int ntaps, input int psize, input int idx);
        int rem;
        rem = ntaps - idx * psize;
        return (rem > psize) ? psize : rem;
    endfunction

endpackage

// File: rtl/da_fir_lut.sv
module da_fir_lut #(
    parameter int N  = 8,
    parameter int CW = 16,
    parameter int SW = 20,
    parameter logic [N*CW-1:0] COEFS = '0
) (
    input  logic [N-1:0]           addr,
    output logic signed [SW-1:0]   sum
);
    localparam int DEPTH = 1 << N;

    function automatic logic signed [SW-1:0] tbl_entry(input int unsigned pat);
        logic signed [SW-1:0] acc;
        acc = '0;
        for (int t = 0; t < N; t++) begin
            if (pat[t]) acc += SW'(signed'(COEFS[t*CW +: CW]));
        end
        return acc;
    endfunction

    logic signed [SW-1:0] rom [DEPTH];

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        localparam logic signed [SW-1:0] VAL = tbl_entry(e);
        assign rom[e] = VAL;
    end

    assign sum = rom[addr];

endmodule

// File: rtl/da_fir_slice.sv
module da_fir_slice
    import da_fir_pkg::*;
#(
    parameter int NTAPS = 10,
    parameter int PSIZE = 8,
    parameter int CW    = 16,
    parameter int SW    = 21,
    parameter logic [NTAPS*CW-1:0] COEFS = '0
) (
    input  logic [NTAPS-1:0]       bits,
    output logic signed [SW-1:0]   total
);
    localparam int NP   = part_count(NTAPS, PSIZE);
    localparam int NPOW = 1 << $clog2(NP);

    logic signed [SW-1:0] psum [NP];
    logic signed [SW-1:0] node [2*NPOW-1];

    for (genvar p = 0; p < NP; p++) begin : g_part
        localparam int NT   = part_taps(NTAPS, PSIZE, p);
        localparam int BASE = p * PSIZE;
        da_fir_lut #(
            .N    (NT),
            .CW   (CW),
            .SW   (SW),
            .COEFS(COEFS[BASE*CW +: NT*CW])
        ) u_lut (
            .addr(bits[BASE +: NT]),
            .sum (psum[p])
        );
    end

    // balanced adder tree, leaves padded with zero
    for (genvar i = 0; i < NPOW; i++) begin : g_leaf
        if (i < NP) begin : g_use
            assign node[NPOW-1+i] = psum[i];
        end else begin : g_pad
            assign node[NPOW-1+i] = '0;
        end
    end

    for (genvar n = 0; n < NPOW - 1; n++) begin : g_add
        assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign total = node[0];

endmodule

// File: rtl/da_fir_top.sv
module da_fir_top #(
    parameter int DW    = 12,
    parameter int IFRAC = 11,
    parameter int OW    = 12,
    parameter int OFRAC = 11,
    parameter int CW    = 16,
    parameter int CFRAC = 16,
    parameter int NTAPS = 10,
    parameter int PSIZE = 8,
    parameter int BPC   = 1,
    parameter logic [NTAPS*CW-1:0] COEFS =
        160'hFB50_09C4_2328_4E20_7D00_7D00_4E20_2328_09C4_FB50
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          out_valid,
    output logic [OW-1:0] out_data
);
    localparam int FOLD  = DW / BPC;
    localparam int CNTW  = (FOLD > 1) ? $clog2(FOLD) : 1;
    localparam int IW    = $clog2(DW);
    localparam int SW    = CW + $clog2(NTAPS) + 1;
    localparam int KW    = SW + BPC + 1;
    localparam int AW    = SW + DW + 1;
    localparam int SHIFT = CFRAC + IFRAC - OFRAC;
    localparam logic signed [AW-1:0] HALF   = AW'(1) << (SHIFT - 1);
    localparam logic signed [AW-1:0] SAT_HI = AW'((1 << (OW - 1)) - 1);
    localparam logic signed [AW-1:0] SAT_LO = ~SAT_HI;

    typedef struct packed {
        logic [NTAPS-1:0][DW-1:0] dly;
        logic signed [AW-1:0]     acc;
        logic [CNTW-1:0]          cnt;
        logic                     busy;
        logic [OW-1:0]            res;
        logic                     vld;
    } state_t;

    state_t s_d, s_q;

    logic [BPC-1:0][NTAPS-1:0] slice_bits;
    logic signed [SW-1:0]      slice_sum [BPC];
    logic signed [KW-1:0]      chunk;
    logic signed [KW-1:0]      term;
    logic signed [AW-1:0]      step;
    logic signed [AW-1:0]      rnd;
    logic signed [AW-1:0]      qv;
    logic [OW-1:0]             satv;
    logic [IW-1:0]             idx;
    logic                      last;
    logic                      accept;

    // one table set per bit position handled in the same clock
    for (genvar b = 0; b < BPC; b++) begin : g_copy
        da_fir_slice #(
            .NTAPS(NTAPS),
            .PSIZE(PSIZE),
            .CW   (CW),
            .SW   (SW),
            .COEFS(COEFS)
        ) u_slice (
            .bits (slice_bits[b]),
            .total(slice_sum[b])
        );
    end

    always_comb begin
        slice_bits = '0;
        for (int b = 0; b < BPC; b++) begin
            idx = IW'(int'(s_q.cnt) * BPC + b);
            for (int t = 0; t < NTAPS; t++) begin
                slice_bits[b][t] = s_q.dly[t][idx];
            end
        end

        chunk = '0;
        for (int b = 0; b < BPC; b++) begin
            term = KW'(slice_sum[b]) <<< b;
            if ((s_q.cnt == CNTW'(FOLD - 1)) && (b == BPC - 1)) chunk = chunk - term;
            else                                              chunk = chunk + term;
        end

        step = (s_q.acc >>> BPC) + (AW'(chunk) <<< (DW - BPC));
        rnd  = step + HALF;
        qv   = rnd >>> SHIFT;
        if (qv > SAT_HI)      satv = OW'(SAT_HI);
        else if (qv < SAT_LO) satv = OW'(SAT_LO);
        else                  satv = OW'(qv);

        last   = s_q.busy && (s_q.cnt == CNTW'(FOLD - 1));
        accept = in_valid && (!s_q.busy || last);

        s_d     = s_q;
        s_d.vld = 1'b0;
        if (s_q.busy) begin
            s_d.acc = step;
            s_d.cnt = s_q.cnt + 1'b1;
            if (last) begin
                s_d.busy = 1'b0;
                s_d.vld  = 1'b1;
                s_d.res  = satv;
                s_d.cnt  = '0;
            end
        end
        if (accept) begin
            s_d.dly  = {s_q.dly[NTAPS-2:0], in_data};
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
            s_d.acc  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign out_valid = s_q.vld;
    assign out_data  = s_q.res;

    // R6
    valid_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(s_q.busy && (s_q.cnt == CNTW'(FOLD - 1))));

    // R6
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> $stable(out_data));

    // R7
    early_strobe_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && s_q.busy && (s_q.cnt != CNTW'(FOLD - 1))) |=> $stable(s_q.dly));

    // R7
    idle_strobe_loads_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !s_q.busy) |=> (s_q.busy && (s_q.dly[0] == $past(in_data))));

    // R8
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !s_q.busy && (s_q.acc == '0) && (s_q.cnt == '0)));

endmodule

// File: tb/test_da_fir_top.sv
module test_da_fir_top;

    localparam int NT = 10;
    localparam int COEF [NT] = '{3000, -7000, 12000, 32767, -32768,
                                 15000, -4000, 800, 21000, -9000};
    // tap i at bits [16*i +: 16] (R1)
    localparam logic [NT*16-1:0] TB_COEFS =
        {16'hDCD8, 16'h5208, 16'h0320, 16'hF060, 16'h3A98,
         16'h8000, 16'h7FFF, 16'h2EE0, 16'hE4A8, 16'h0BB8};
    localparam int FOLD [2] = '{12, 3};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic        a_vld, b_vld;
    logic [11:0] a_dat, b_dat;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;
    string tag = "R8";

    int hist [2][NT];
    int last_e [2];
    int qa_val[$], qa_due[$], qb_val[$], qb_due[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    da_fir_top #(.NTAPS(NT), .BPC(1), .COEFS(TB_COEFS)) i_da_fir_top (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(a_vld), .out_data(a_dat));

    da_fir_top #(.NTAPS(NT), .BPC(4), .COEFS(TB_COEFS)) i_da_fir_top_wide (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .out_valid(b_vld), .out_data(b_dat));

    function automatic int ref_out(input int d);
        longint acc = 0;
        for (int i = 0; i < NT; i++) acc += longint'(COEF[i]) * longint'(hist[d][i]);
        acc = (acc + 64'sd32768) >>> 16;
        if (acc > 2047)  acc = 2047;
        if (acc < -2048) acc = -2048;
        return int'(acc);
    endfunction

    task automatic fail(input string req, input int d, input int got, input int exp);
        errors++;
        $display("FAIL %s dut%0d cycle %0d: actual %0d expected %0d", req, d, cyc, got, exp);
    endtask

    task automatic mon(input int d, input logic v, input logic [11:0] o,
                       ref int qv[$], ref int qd[$]);
        int e, due;
        if (v) begin
            checks++;
            if (qv.size() == 0) begin
                fail("R6/R7 unexpected out_valid", d, 1, 0);
            end else begin
                e   = qv.pop_front();
                due = qd.pop_front();
                if (cyc != due) fail("R4 latency", d, cyc, due);
                checks++;
                if (int'($signed(o)) != e) fail(tag, d, int'($signed(o)), e);
            end
        end else if (qd.size() > 0 && cyc > qd[0]) begin
            checks++;
            fail("R4/R6 missing out_valid", d, cyc, qd[0]);
            void'(qv.pop_front());
            void'(qd.pop_front());
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            mon(0, a_vld, a_dat, qa_val, qa_due);
            mon(1, b_vld, b_dat, qb_val, qb_due);
        end
    end

    task automatic clear_model();
        for (int d = 0; d < 2; d++) begin
            for (int i = 0; i < NT; i++) hist[d][i] = 0;
            last_e[d] = -1000;
        end
        qa_val.delete(); qa_due.delete(); qb_val.delete(); qb_due.delete();
    endtask

    // call right after a negedge; drives one strobe then waits gap cycles
    task automatic send(input int x, input int gap);
        int e;
        in_valid = 1'b1;
        in_data  = 12'(x);
        e = cyc + 1;
        for (int d = 0; d < 2; d++) begin
            if (e - last_e[d] >= FOLD[d]) begin
                for (int i = NT - 1; i > 0; i--) hist[d][i] = hist[d][i-1];
                hist[d][0] = x;
                last_e[d]  = e;
                if (d == 0) begin qa_val.push_back(ref_out(0)); qa_due.push_back(e + FOLD[0]); end
                else        begin qb_val.push_back(ref_out(1)); qb_due.push_back(e + FOLD[1]); end
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap - 1) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        checks++;
        if (a_vld !== 1'b0 || a_dat !== 12'd0) fail(req, 0, int'(a_dat), 0);
        checks++;
        if (b_vld !== 1'b0 || b_dat !== 12'd0) fail(req, 1, int'(b_dat), 0);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        int x;
        clear_model();
        seed = 32'h5EED;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        // R8: reset state
        check_idle("R8 reset state");
        rst = 1'b0;
        @(negedge clk);

        // R1/R3: positive impulse walks every coefficient out in tap order
        tag = "R1/R3 impulse";
        send(2047, 14);
        for (int i = 0; i < NT; i++) send(0, 14);

        // R5: negative full-scale impulse
        tag = "R5 negative impulse";
        send(-2048, 14);
        for (int i = 0; i < NT; i++) send(0, 14);

        // R9: push sum above the positive limit, then below the negative limit
        tag = "R9 saturate high";
        for (int i = NT - 1; i >= 0; i--) send(COEF[i] > 0 ? 2047 : -2048, 14);
        tag = "R9 saturate low";
        for (int i = NT - 1; i >= 0; i--) send(COEF[i] > 0 ? -2048 : 2047, 14);

        // R2: rounding with small values
        tag = "R2 small values";
        for (int i = 0; i < 12; i++) send(i - 6, 13);

        // R7: strobes at exactly F for the narrow instance, then one cycle early
        tag = "R7 exact spacing";
        for (int i = 0; i < 15; i++) send(int'($urandom_range(0, 4095)) - 2048, 12);
        tag = "R7 early strobes";
        for (int i = 0; i < 15; i++) send(int'($urandom_range(0, 4095)) - 2048, 11);
        repeat (16) @(negedge clk);

        // R8: reset in the middle of a computation
        tag = "R8 reset mid-run";
        send(1500, 5);
        rst = 1'b1;
        clear_model();
        repeat (3) @(negedge clk);
        check_idle("R8 reset mid-run");
        rst = 1'b0;
        @(negedge clk);
        send(700, 14);

        // R2/R4/R7: random samples and gaps
        tag = "R2 random";
        for (int i = 0; i < 400; i++) begin
            x = (i % 37 == 0) ? -2048 : ((i % 41 == 0) ? 2047 : int'($urandom_range(0, 4095)) - 2048);
            send(x, int'($urandom_range(1, 16)));
        end
        repeat (20) @(negedge clk);

        checks++;
        if (qa_val.size() != 0 || qb_val.size() != 0)
            fail("R6 results left pending", 0, qa_val.size() + qb_val.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule